// File: doc/BRIEF.md
# Vector Element to Scalar Extractor

This block takes one 32-bit instruction word per cycle. The word asks for one unsigned element to be copied out of a 128-bit vector register into a scalar destination. The block checks the fixed opcode bits and reads the element size and position from a 5-bit immediate. The Q bit selects a 32-bit or a 64-bit destination. The block flags any encoding that is reserved, or whose size and Q bit disagree, as undefined. For a legal word it picks the element out of the supplied vector operand and zero-extends it to the destination width.

Two enable inputs model the floating-point and SIMD access controls. Reading element zero needs only the floating-point enable. Any other element needs both enables. When an enable that is needed is missing, the block raises a disabled flag in place of a result. A single registered stage returns the destination and source register numbers, the result, the width flag and the three status flags one cycle after the request.

Top module: `elem_extract_unit`

## Requirements
- R1: While rst_n is low at a clock edge, valid_out is cleared to 0 and stays 0 until a request is accepted after reset.
- R2: valid_out equals the valid_in of the previous cycle. All other outputs load only when valid_in is 1 and otherwise hold their values.
- R3: A word matches when bit 31=0, bit 29=0, bits 28..21=01110000, bit 15=0, bits 14..11=0111 and bit 10=1. A word that does not match gives nomatch=1 with result=0, undef=0 and disabled=0.
- R4: A matching word whose immediate (bits 20..16) has bits 3..0 all zero gives undef=1.
- R5: The size code is the position of the lowest set bit in immediate bits 3..0. The element width is 8, 16, 32 or 64 bits for codes 0 to 3.
- R6: With Q (bit 30) = 1 the only legal immediate is x1000. Q=1 with a narrower element is undefined, and so is Q=0 with a 64-bit element.
- R7: The element index is the immediate's bits from bit 4 down to bit size+1, read as unsigned. The element occupies vector bits starting at index times the element width.
- R8: A legal element is zero-extended to the destination width, and is64 equals Q, so with Q=0 the result bits 63..32 are 0.
- R9: An undefined word gives result=0 and disabled=0, whatever the enables are.
- R10: A legal word with index 0 needs fp_en=1. One with a nonzero index needs fp_en=1 and simd_en=1. If a needed enable is missing, disabled=1 and result=0.
- R11: rd returns instruction bits 4..0 and rn returns bits 9..5 for every accepted word, whether it matches or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Request valid |
| instr | input | 32 | Instruction word |
| vec | input | 128 | Source vector operand |
| fp_en | input | 1 | Floating-point access enable |
| simd_en | input | 1 | SIMD access enable |
| valid_out | output | 1 | Response valid, one cycle after the request |
| rd | output | 5 | Destination register number |
| rn | output | 5 | Source register number |
| is64 | output | 1 | Destination is 64 bits wide |
| result | output | 64 | Zero-extended element |
| undef | output | 1 | Encoding is undefined |
| disabled | output | 1 | A required enable is missing |
| nomatch | output | 1 | Fixed opcode bits do not match |

## Verification
The undefined check and the enable check both act on the same accepted word, so both flags can be candidates in one cycle. The bench provokes this by sending undefined immediates, including the all-zero size field and both kinds of Q mismatch, with one or both enables cleared. It judges the outcome by requiring undef=1, disabled=0 and a zero result. In the same way, a word with wrong opcode bits and cleared enables must show only nomatch.

// File: rtl/elx_pkg.sv
// Package: shared constants and the decoded-request record for the
// element extractor. Assumes the fixed 32-bit instruction layout.
package elx_pkg;
    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 5;
    localparam int SZ_W    = 2;
    localparam int NSIZES  = 4;
    // Fixed opcode bits: 31, 29, 28..21, 15, 14..10
    localparam logic [INSTR_W-1:0] OPC_MASK = 32'hBFE0_FC00;
    localparam logic [INSTR_W-1:0] OPC_VAL  = 32'h0E00_3C00;

    typedef struct packed {
        logic             match;
        logic             undef;
        logic             wide;
        logic [SZ_W-1:0]  size;
        logic [3:0]       index;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rn;
    } dec_t;
endpackage

// File: rtl/elx_decode.sv
// Module: instruction decoder. Checks the opcode bits, derives the size
// code and element index from the immediate, and flags undefined forms.
// Assumes the instruction layout fixed in elx_pkg.
module elx_decode
    import elx_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [IMM_W-1:0] imm;
    logic             q_bit;
    logic [SZ_W-1:0]  sz;
    logic [3:0]       idx;
    logic             match;
    logic             bad;

    assign imm   = instr[20:16];
    assign q_bit = instr[30];
    assign match = ((instr & OPC_MASK) == OPC_VAL);

    // Size code: position of the lowest set bit in imm[3:0]
    always_comb begin
        if (imm[0])      sz = 2'd0;
        else if (imm[1]) sz = 2'd1;
        else if (imm[2]) sz = 2'd2;
        else             sz = 2'd3;
    end

    // Index: immediate bits above the size marker
    always_comb begin
        unique case (sz)
            2'd0:    idx = imm[4:1];
            2'd1:    idx = {1'b0, imm[4:2]};
            2'd2:    idx = {2'b0, imm[4:3]};
            default: idx = {3'b0, imm[4]};
        endcase
    end

    // Undefined: empty size field or Q disagreeing with element size
    always_comb begin
        bad = (imm[3:0] == 4'b0000)
            || (q_bit && (sz != 2'd3))
            || (!q_bit && (sz == 2'd3));
    end

    // Pack the decoded record
    always_comb begin
        dec.match = match;
        dec.undef = match && bad;
        dec.wide  = q_bit;
        dec.size  = sz;
        dec.index = idx;
        dec.rd    = instr[4:0];
        dec.rn    = instr[9:5];
    end
endmodule

// File: rtl/elx_select.sv
// Module: element selector. Builds one zero-extended candidate per
// element size and picks the one named by the size code. Assumes the
// vector width is a multiple of the widest element (64 bits).
module elx_select
    import elx_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int RES_W = 64,
    localparam int IDX_W = $clog2(VEC_W / 8)
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [SZ_W-1:0]  size,
    input  logic [IDX_W-1:0] index,
    output logic [RES_W-1:0] elem
);
    logic [RES_W-1:0] cand [NSIZES];

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        localparam int EW  = 8 << s;
        localparam int NE  = VEC_W / EW;
        localparam int IW  = (NE > 1) ? $clog2(NE) : 1;
        logic [IW-1:0] sub;
        logic [EW-1:0] piece;
        assign sub = index[IW-1:0];
        // Slice the element of this width at the indexed position
        always_comb begin
            piece   = vec[sub*EW +: EW];
            cand[s] = RES_W'(piece);
        end
    end

    // Pick the candidate of the decoded size
    always_comb begin
        elem = cand[size];
    end
endmodule

// File: rtl/elx_outreg.sv
// Module: output register stage. valid_out follows valid_in by one
// cycle; payload loads only on an accepted request. Synchronous
// active-low reset clears the stage.
module elx_outreg
    import elx_pkg::*;
#(
    parameter int RES_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic [REG_W-1:0] rd_d,
    input  logic [REG_W-1:0] rn_d,
    input  logic             is64_d,
    input  logic [RES_W-1:0] result_d,
    input  logic             undef_d,
    input  logic             disabled_d,
    input  logic             nomatch_d,
    output logic             valid_out,
    output logic [REG_W-1:0] rd,
    output logic [REG_W-1:0] rn,
    output logic             is64,
    output logic [RES_W-1:0] result,
    output logic             undef,
    output logic             disabled,
    output logic             nomatch
);
    // Valid flag pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) valid_out <= 1'b0;
        else        valid_out <= valid_in;
    end

    // Payload capture on accepted requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd       <= '0;
            rn       <= '0;
            is64     <= 1'b0;
            result   <= '0;
            undef    <= 1'b0;
            disabled <= 1'b0;
            nomatch  <= 1'b0;
        end else if (valid_in) begin
            rd       <= rd_d;
            rn       <= rn_d;
            is64     <= is64_d;
            result   <= result_d;
            undef    <= undef_d;
            disabled <= disabled_d;
            nomatch  <= nomatch_d;
        end
    end
endmodule

// File: rtl/elem_extract_unit.sv
// Module: top of the vector-element-to-scalar extractor. Decodes the
// word, checks enables, selects and zero-extends the element, and
// registers the response. Assumes one request per cycle, no stall.
module elem_extract_unit
    import elx_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int RES_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_in,
    input  logic [INSTR_W-1:0] instr,
    input  logic [VEC_W-1:0]   vec,
    input  logic               fp_en,
    input  logic               simd_en,
    output logic               valid_out,
    output logic [REG_W-1:0]   rd,
    output logic [REG_W-1:0]   rn,
    output logic               is64,
    output logic [RES_W-1:0]   result,
    output logic               undef,
    output logic               disabled,
    output logic               nomatch
);
    localparam int IDX_W = $clog2(VEC_W / 8);

    dec_t             dec;
    logic [RES_W-1:0] elem;
    logic [RES_W-1:0] res_d;
    logic             dis_d;
    logic             allowed;

    elx_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    elx_select #(.VEC_W(VEC_W), .RES_W(RES_W)) u_sel (
        .vec   (vec),
        .size  (dec.size),
        .index (dec.index[IDX_W-1:0]),
        .elem  (elem)
    );

    // Enable rule: index 0 needs fp only, others need fp and simd
    always_comb begin
        allowed = fp_en && ((dec.index == '0) || simd_en);
        dis_d   = dec.match && !dec.undef && !allowed;
    end

    // Result gating: zero on no-match, undefined or disabled
    always_comb begin
        if (!dec.match || dec.undef || dis_d) res_d = '0;
        else                                  res_d = elem;
    end

    elx_outreg #(.RES_W(RES_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_in   (valid_in),
        .rd_d       (dec.rd),
        .rn_d       (dec.rn),
        .is64_d     (dec.wide),
        .result_d   (res_d),
        .undef_d    (dec.undef),
        .disabled_d (dis_d),
        .nomatch_d  (!dec.match),
        .valid_out  (valid_out),
        .rd         (rd),
        .rn         (rn),
        .is64       (is64),
        .result     (result),
        .undef      (undef),
        .disabled   (disabled),
        .nomatch    (nomatch)
    );
endmodule

// File: rtl/elx_checker.sv
// Module: assertion checker for elem_extract_unit, attached by bind.
module elx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_in,
    input logic [31:0] instr,
    input logic        valid_out,
    input logic        is64,
    input logic [63:0] result,
    input logic        undef,
    input logic        disabled,
    input logic        nomatch
);
    logic armed;
    // Set once a clock edge has passed with reset released
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (valid_out == $past(valid_in)));
    p_nomatch_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && nomatch) |-> (!undef && !disabled && result == 64'd0));
    p_q_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(valid_in) && valid_out && is64 && !undef && !nomatch)
        |-> ($past(instr[19:16]) == 4'b1000));
    p_narrow_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && !is64) |-> (result[63:32] == 32'd0));
    p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && undef) |-> (result == 64'd0 && !disabled));
    p_disabled_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && disabled) |-> (result == 64'd0));
endmodule

bind elem_extract_unit elx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .instr     (instr),
    .valid_out (valid_out),
    .is64      (is64),
    .result    (result),
    .undef     (undef),
    .disabled  (disabled),
    .nomatch   (nomatch)
);

// File: tb/sim_elem_extract_unit.sv
module sim_elem_extract_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] vec = '0;
    logic         fp_en = 1'b0;
    logic         simd_en = 1'b0;
    logic         valid_out, is64, undef, disabled, nomatch;
    logic [4:0]   rd, rn;
    logic [63:0]  result;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    elem_extract_unit u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit q, input logic [4:0] imm, input logic [4:0] n, input logic [4:0] d);
        return {1'b0, q, 1'b0, 8'b01110000, imm, 1'b0, 4'b0111, 1'b1, n, d};
    endfunction

    // Reference model: returns {undef, disabled, result} for a matching word
    task automatic ref_model(input bit q, input logic [4:0] imm, input logic [127:0] v,
                             input bit fe, input bit se,
                             output bit e_undef, output bit e_dis, output logic [63:0] e_res);
        int sz = 3;
        int esz, idx;
        logic [127:0] sh;
        for (int b = 3; b >= 0; b--) if (imm[b]) sz = b;
        esz = 8 << sz;
        idx = int'(imm) >> (sz + 1);
        e_undef = (imm[3:0] == 0) || (q != (sz == 3));
        e_dis = !e_undef && !(fe && (idx == 0 || se));
        sh = v >> (idx * esz);
        e_res = (e_undef || e_dis) ? 64'd0 : ((esz == 64) ? sh[63:0] : (sh[63:0] & ((64'd1 << esz) - 1)));
    endtask

    task automatic issue(input logic [31:0] w, input logic [127:0] v, input bit fe, input bit se);
        @(negedge clk);
        instr = w; vec = v; fp_en = fe; simd_en = se; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        valid_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(valid_out == 1'b0, "R1 valid_out in reset", 64'(valid_out), 64'd0);
        valid_in = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_out == 1'b0, "R1 valid_out after reset", 64'(valid_out), 64'd0);
    endtask

    task automatic t_sweep(input bit fe, input bit se);
        bit eu, ed;
        logic [63:0] er;
        logic [127:0] v;
        for (int q = 0; q < 2; q++) begin
            for (int i = 0; i < 32; i++) begin
                v = {$urandom, $urandom, $urandom, $urandom};
                ref_model(q[0], i[4:0], v, fe, se, eu, ed, er);
                issue(mk(q[0], i[4:0], 5'd3, 5'd9), v, fe, se);
                chk(valid_out === 1'b1 && nomatch === 1'b0, "R2 R3 valid/match", 64'({valid_out, nomatch}), 64'b10);
                chk(undef === eu, "R4 R5 R6 undef", 64'(undef), 64'(eu));
                chk(disabled === ed, "R10 disabled", 64'(disabled), 64'(ed));
                chk(result === er, "R7 R8 R9 result", result, er);
                chk(is64 === q[0], "R8 is64", 64'(is64), 64'(q));
            end
        end
    endtask

    task automatic t_nomatch;
        int fixed_bits [20] = '{31,29,28,27,26,25,24,23,22,21,15,14,13,12,11,10,31,29,10,15};
        for (int k = 0; k < 20; k++) begin
            issue(mk(1'b0, 5'b00101, 5'd1, 5'd2) ^ (32'd1 << fixed_bits[k]), {4{32'hDEADBEEF}}, 1'b0, 1'b0);
            chk(nomatch === 1'b1 && undef === 1'b0 && disabled === 1'b0 && result === 64'd0,
                "R3 mismatch clean", {nomatch, undef, disabled, result[60:0]}, 64'h8000_0000_0000_0000);
        end
    endtask

    task automatic t_undef_vs_disabled;
        logic [4:0] bad_imm [3] = '{5'b10000, 5'b00001, 5'b01000};
        bit         bad_q   [3] = '{1'b0, 1'b1, 1'b0};
        for (int k = 0; k < 3; k++) begin
            issue(mk(bad_q[k], bad_imm[k], 5'd0, 5'd0), {4{32'hFFFFFFFF}}, 1'b0, 1'b0);
            chk(undef === 1'b1 && disabled === 1'b0 && result === 64'd0, "R9 undef beats disabled",
                {undef, disabled, result[61:0]}, 64'h8000_0000_0000_0000);
        end
    endtask

    task automatic t_fields;
        for (int k = 0; k < 8; k++) begin
            logic [4:0] n = 5'($urandom);
            logic [4:0] d = 5'($urandom);
            issue(mk(1'b1, 5'b11000, n, d) ^ (k[0] ? 32'h8000_0000 : 32'd0), '0, 1'b1, 1'b1);
            chk(rd === d && rn === n, "R11 rd rn fields", 64'({rd, rn}), 64'({d, n}));
        end
    endtask

    task automatic t_hold;
        logic [63:0] keep;
        issue(mk(1'b1, 5'b11000, 5'd0, 5'd7), {64'h1122334455667788, 64'h0}, 1'b1, 1'b1);
        keep = result;
        chk(keep === 64'h1122334455667788, "R7 upper doubleword", keep, 64'h1122334455667788);
        instr = mk(1'b0, 5'b00001, 5'd0, 5'd1); vec = '1;
        repeat (2) @(negedge clk);
        chk(valid_out === 1'b0 && result === keep && rd === 5'd7, "R2 hold when idle", result, keep);
    endtask

    initial begin
        t_reset();
        t_sweep(1'b1, 1'b1);
        t_sweep(1'b1, 1'b0);
        t_sweep(1'b0, 1'b1);
        t_nomatch();
        t_undef_vs_disabled();
        t_fields();
        t_hold();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule